// File: doc/BRIEF.md
# Coprocessor Prefetch Queue Tracker

This block runs beside a host CPU whose instruction fetches run ahead of execution. Because a fetch on the bus says nothing about when the host executes that byte, the block keeps a mirror of the host's prefetch queue. Each code-fetch byte seen on the bus is pushed into a local byte queue. A 2-bit queue-status input from the host says, each cycle, whether the host took the first byte of an instruction, took a later byte, flushed its queue, or did nothing. The block pops its mirror in step with that status.

Bytes popped as instruction starts are checked for the escape opcode class, whose top five bits are `11011`. When an escape byte is followed by a later-byte pop, the block reports the escape instruction. It gives the 3-bit opcode field of the first byte and the mode, opcode and register/memory fields of the second byte, with a single-cycle valid strobe.

Two host variants exist, with different prefetch queue depths. The block samples a strap input while reset is held and fixes its queue depth from it until the next reset.

Top module: `esc_queue_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `esc_valid` is 0 and the mirror queue is empty, so status pops that follow reset report nothing until bytes are fetched.
- R2: `host_wide` is sampled only while `rst` is high. A value of 1 selects a queue depth of 6 bytes and a value of 0 selects 4 bytes. Changes on `host_wide` after reset have no effect.
- R3: A byte is pushed at a clock edge where `fetch_valid` is 1, unless the queue already holds the selected depth at that edge. In that case the byte is discarded.
- R4: `qstat` encoding: 00 does nothing, 01 pops one byte as an instruction's first byte, 10 flushes, and 11 pops one byte as a later byte. A pop status on an empty queue is ignored. Bytes are popped in the order they were fetched.
- R5: A byte popped under status 01 starts an escape instruction only when its bits [7:3] equal 11011. Any other first byte, and any byte popped under status 11 with no escape pending, produces no report.
- R6: With an escape pending, a pop under status 11 reports the instruction. `esc_valid` is 1 for exactly the one cycle after that status cycle. In that cycle `esc_op_hi` = first byte [2:0], `esc_mode` = second byte [7:6], `esc_op_lo` = second byte [5:3] and `esc_rm` = second byte [2:0].
- R7: Status 10 empties the queue at that edge and drops any pending escape. A byte fetched in the same cycle as the flush is discarded.
- R8: A status 01 pop that arrives while an escape is pending abandons the pending one. The new byte is then judged as a fresh first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wide | input | 1 | Host variant strap, sampled during reset (1 = 6-byte queue, 0 = 4-byte queue) |
| fetch_valid | input | 1 | A code-fetch byte is on `fetch_byte` this cycle |
| fetch_byte | input | 8 | Fetched instruction byte |
| qstat | input | 2 | Host queue status |
| esc_valid | output | 1 | One-cycle strobe for a decoded escape instruction |
| esc_op_hi | output | 3 | Opcode field from the escape byte |
| esc_mode | output | 2 | Mode field from the second byte |
| esc_op_lo | output | 3 | Opcode field from the second byte |
| esc_rm | output | 3 | Register/memory field from the second byte |

## Verification
The hardest case to reach is the full-queue boundary for each variant: an escape byte that one depth accepts and the other discards. The bench fills the queue with four non-escape bytes and then fetches an escape pair. It drains under status 01 and then 11, after a reset with the narrow strap and after one with the wide strap. Only the wide run may report. In the narrow run the strap is also raised after reset, so a design that reads the strap live would report too.

// File: rtl/esc_trk_pkg.sv
package esc_trk_pkg;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;

  typedef struct packed {
    logic [2:0] op_hi;
    logic [1:0] mode;
    logic [2:0] op_lo;
    logic [2:0] rm;
  } esc_fields_t;

  localparam logic [4:0] ESC_PREFIX = 5'b11011;

endpackage

// File: rtl/host_variant.sv
module host_variant #(
  parameter int DEPTH_WIDE   = 6,
  parameter int DEPTH_NARROW = 4,
  localparam int MAXD = (DEPTH_WIDE > DEPTH_NARROW) ? DEPTH_WIDE : DEPTH_NARROW,
  localparam int CW   = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide_in,
  output logic [CW-1:0] depth_lim
);

  localparam logic [CW-1:0] LIM_W = CW'(DEPTH_WIDE);
  localparam logic [CW-1:0] LIM_N = CW'(DEPTH_NARROW);

  always_ff @(posedge clk) begin
    if (rst) depth_lim <= wide_in ? LIM_W : LIM_N;
  end

endmodule

// File: rtl/mirror_queue.sv
module mirror_queue #(
  parameter int W         = 8,
  parameter int MAX_DEPTH = 6,
  localparam int CW = $clog2(MAX_DEPTH + 1),
  localparam int AW = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [CW-1:0] depth_lim,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic          head_ok,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [2**AW];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;
  logic [AW-1:0] last_idx;

  assign last_idx  = AW'(depth_lim - 1'b1);
  assign head_ok   = (count != '0);
  assign head_data = mem[rd_ptr];
  assign do_push   = push && !flush && (count < depth_lim);
  assign do_pop    = pop && !flush && head_ok;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == last_idx) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == last_idx) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/esc_decoder.sv
module esc_decoder
  import esc_trk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  qstat,
  input  logic        byte_ok,
  input  logic [7:0]  byte_in,
  output logic        out_valid,
  output esc_fields_t out_fields
);

  typedef enum logic {ST_SCAN, ST_OPERAND} dec_st_e;

  dec_st_e    st;
  logic [2:0] op_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_SCAN;
      op_pend    <= '0;
      out_valid  <= 1'b0;
      out_fields <= '0;
    end else begin
      out_valid <= 1'b0;
      case (qstat)
        QS_FLUSH: st <= ST_SCAN;
        QS_FIRST: begin
          if (byte_ok) begin
            if (byte_in[7:3] == ESC_PREFIX) begin
              op_pend <= byte_in[2:0];
              st      <= ST_OPERAND;
            end else begin
              st <= ST_SCAN;
            end
          end
        end
        QS_NEXT: begin
          if (byte_ok && st == ST_OPERAND) begin
            out_fields.op_hi <= op_pend;
            out_fields.mode  <= byte_in[7:6];
            out_fields.op_lo <= byte_in[5:3];
            out_fields.rm    <= byte_in[2:0];
            out_valid        <= 1'b1;
            st               <= ST_SCAN;
          end
        end
        default: st <= st;
      endcase
    end
  end

endmodule

// File: rtl/esc_queue_tracker.sv
module esc_queue_tracker
  import esc_trk_pkg::*;
#(
  parameter int DEPTH_WIDE   = 6,
  parameter int DEPTH_NARROW = 4,
  localparam int MAXD  = (DEPTH_WIDE > DEPTH_NARROW) ? DEPTH_WIDE : DEPTH_NARROW,
  localparam int CNT_W = $clog2(MAXD + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wide,
  input  logic       fetch_valid,
  input  logic [7:0] fetch_byte,
  input  logic [1:0] qstat,
  output logic       esc_valid,
  output logic [2:0] esc_op_hi,
  output logic [1:0] esc_mode,
  output logic [2:0] esc_op_lo,
  output logic [2:0] esc_rm
);

  logic [CNT_W-1:0] depth_lim;
  logic [CNT_W-1:0] q_count;
  logic [7:0]       head_byte;
  logic             head_ok;
  logic             q_pop, q_flush;
  esc_fields_t      fields;

  assign q_pop   = (qstat == QS_FIRST) || (qstat == QS_NEXT);
  assign q_flush = (qstat == QS_FLUSH);

  host_variant #(
    .DEPTH_WIDE  (DEPTH_WIDE),
    .DEPTH_NARROW(DEPTH_NARROW)
  ) u_variant (
    .clk      (clk),
    .rst      (rst),
    .wide_in  (host_wide),
    .depth_lim(depth_lim)
  );

  mirror_queue #(
    .W        (8),
    .MAX_DEPTH(MAXD)
  ) u_queue (
    .clk      (clk),
    .rst      (rst),
    .flush    (q_flush),
    .depth_lim(depth_lim),
    .push     (fetch_valid),
    .push_data(fetch_byte),
    .pop      (q_pop),
    .head_data(head_byte),
    .head_ok  (head_ok),
    .count    (q_count)
  );

  esc_decoder u_dec (
    .clk       (clk),
    .rst       (rst),
    .qstat     (qstat),
    .byte_ok   (head_ok),
    .byte_in   (head_byte),
    .out_valid (esc_valid),
    .out_fields(fields)
  );

  assign esc_op_hi = fields.op_hi;
  assign esc_mode  = fields.mode;
  assign esc_op_lo = fields.op_lo;
  assign esc_rm    = fields.rm;

endmodule

// File: rtl/esc_tracker_chk.sv
module esc_tracker_chk #(
  parameter int CW           = 3,
  parameter int DEPTH_WIDE   = 6,
  parameter int DEPTH_NARROW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    qstat,
  input logic          fetch_valid,
  input logic          esc_valid,
  input logic [CW-1:0] q_count,
  input logic [CW-1:0] depth_lim
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    q_count <= depth_lim); // R3

  AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (depth_lim == CW'(DEPTH_WIDE)) || (depth_lim == CW'(DEPTH_NARROW))); // R2

  AST_DEPTH_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(depth_lim)); // R2

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (qstat == 2'b10) |=> (q_count == '0)); // R7

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (qstat == 2'b00 && !fetch_valid) |=> $stable(q_count)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    esc_valid |=> !esc_valid); // R6

  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    esc_valid |-> ($past(qstat) == 2'b11)); // R6

endmodule

bind esc_queue_tracker esc_tracker_chk #(
  .CW          (CNT_W),
  .DEPTH_WIDE  (DEPTH_WIDE),
  .DEPTH_NARROW(DEPTH_NARROW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .qstat      (qstat),
  .fetch_valid(fetch_valid),
  .esc_valid  (esc_valid),
  .q_count    (q_count),
  .depth_lim  (depth_lim)
);

// File: tb/esc_queue_tracker_test.sv
module esc_queue_tracker_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wide = 1'b1;
  logic       fetch_valid = 1'b0;
  logic [7:0] fetch_byte = '0;
  logic [1:0] qstat = 2'b00;
  logic       esc_valid;
  logic [2:0] esc_op_hi, esc_op_lo, esc_rm;
  logic [1:0] esc_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  esc_queue_tracker uut (
    .clk(clk), .rst(rst), .host_wide(host_wide),
    .fetch_valid(fetch_valid), .fetch_byte(fetch_byte), .qstat(qstat),
    .esc_valid(esc_valid), .esc_op_hi(esc_op_hi), .esc_mode(esc_mode),
    .esc_op_lo(esc_op_lo), .esc_rm(esc_rm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic fv, input logic [7:0] fb, input logic [1:0] qs);
    fetch_valid = fv;
    fetch_byte  = fb;
    qstat       = qs;
    @(posedge clk);
    @(negedge clk);
    fetch_valid = 1'b0;
    fetch_byte  = '0;
    qstat       = 2'b00;
  endtask

  task automatic push(input logic [7:0] b);
    step(1'b1, b, 2'b00);
  endtask

  function automatic int fields();
    return int'({esc_op_hi, esc_mode, esc_op_lo, esc_rm});
  endfunction

  task automatic do_reset(input logic wide);
    rst = 1'b1;
    host_wide = wide;
    step(1'b0, 8'h00, 2'b00);
    step(1'b0, 8'h00, 2'b00);
    check(esc_valid == 1'b0, "R1 valid low in reset", esc_valid, 0);
    rst = 1'b0;
    host_wide = ~wide;
    step(1'b0, 8'h00, 2'b00);
    check(esc_valid == 1'b0, "R1 valid low after reset", esc_valid, 0);
  endtask

  task automatic t_empty_after_reset();
    do_reset(1'b1);
    step(1'b0, 8'h00, 2'b01);
    step(1'b0, 8'h00, 2'b11);
    check(esc_valid == 1'b0, "R1 empty queue pops report nothing", esc_valid, 0);
    push(8'hDA);
    push(8'h1F);
    step(1'b0, 8'h00, 2'b01);
    step(1'b0, 8'h00, 2'b11);
    check(esc_valid == 1'b1, "R4 pops on empty ignored, later pair decodes", esc_valid, 1);
    check(fields() == 11'b010_00_011_111, "R4 fields after empty pops", fields(), 11'b010_00_011_111);
  endtask

  task automatic t_basic();
    do_reset(1'b1);
    push(8'hD9);
    push(8'h6D);
    step(1'b0, 8'h00, 2'b01);
    check(esc_valid == 1'b0, "R6 no strobe after first byte", esc_valid, 0);
    step(1'b0, 8'h00, 2'b11);
    check(esc_valid == 1'b1, "R6 strobe after second byte", esc_valid, 1);
    check(fields() == 11'b001_01_101_101, "R6 field split", fields(), 11'b001_01_101_101);
    step(1'b0, 8'h00, 2'b00);
    check(esc_valid == 1'b0, "R6 strobe one cycle", esc_valid, 0);
  endtask

  task automatic t_nonesc_and_idle();
    do_reset(1'b1);
    push(8'h8B);
    push(8'h45);
    step(1'b0, 8'h00, 2'b01);
    step(1'b0, 8'h00, 2'b11);
    check(esc_valid == 1'b0, "R5 non-escape first byte", esc_valid, 0);
    push(8'hC5);
    step(1'b0, 8'h00, 2'b11);
    check(esc_valid == 1'b0, "R5 later byte with nothing pending", esc_valid, 0);
    push(8'hDF);
    push(8'hC0);
    step(1'b0, 8'h00, 2'b00);
    step(1'b0, 8'h00, 2'b00);
    check(esc_valid == 1'b0, "R4 idle status pops nothing", esc_valid, 0);
    step(1'b0, 8'h00, 2'b01);
    step(1'b0, 8'h00, 2'b11);
    check(esc_valid == 1'b1, "R4 bytes kept across idle status", esc_valid, 1);
    check(fields() == 11'b111_11_000_000, "R4 fetch order kept", fields(), 11'b111_11_000_000);
  endtask

  task automatic t_depth(input logic wide);
    do_reset(wide);
    for (int i = 0; i < 4; i++) push(8'h90);
    push(8'hD8);
    push(8'hE1);
    for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 2'b01);
    step(1'b0, 8'h00, 2'b11);
    if (wide) begin
      check(esc_valid == 1'b1, "R2 wide variant holds 6 bytes", esc_valid, 1);
      check(fields() == 11'b000_11_100_001, "R3 bytes 5 and 6 kept", fields(), 11'b000_11_100_001);
    end else begin
      check(esc_valid == 1'b0, "R3 narrow variant drops bytes past 4", esc_valid, 0);
    end
  endtask

  task automatic t_flush();
    do_reset(1'b1);
    push(8'hD9);
    step(1'b0, 8'h00, 2'b01);
    push(8'h6D);
    step(1'b0, 8'h00, 2'b10);
    step(1'b0, 8'h00, 2'b11);
    check(esc_valid == 1'b0, "R7 flush drops pending and queue", esc_valid, 0);
    step(1'b1, 8'hD8, 2'b10);
    push(8'h00);
    step(1'b0, 8'h00, 2'b01);
    step(1'b0, 8'h00, 2'b11);
    check(esc_valid == 1'b0, "R7 fetch during flush discarded", esc_valid, 0);
  endtask

  task automatic t_restart();
    do_reset(1'b1);
    push(8'hD9);
    push(8'hD8);
    push(8'hC3);
    step(1'b0, 8'h00, 2'b01);
    step(1'b0, 8'h00, 2'b01);
    check(esc_valid == 1'b0, "R8 no strobe on restart", esc_valid, 0);
    step(1'b0, 8'h00, 2'b11);
    check(esc_valid == 1'b1, "R8 restarted escape reported", esc_valid, 1);
    check(fields() == 11'b000_11_000_011, "R8 new first byte used", fields(), 11'b000_11_000_011);
  endtask

  initial begin
    @(negedge clk);
    t_empty_after_reset();
    t_basic();
    t_nonesc_and_idle();
    t_depth(1'b0);
    t_depth(1'b1);
    t_flush();
    t_restart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule